// File: doc/BRIEF.md
# CCD Electronic Shutter Sequencer

This block sequences exposure for a progressive-scan CCD at line granularity. After each vertical sync fall it counts horizontal sync falls. It flags the line in which the sensor charge is transferred to the vertical registers (the readout line). It opens a write-enable window for the rest of that frame. It drives a per-line enable for the substrate discharge pulse, which sets where the exposure starts. Exposure length is the sum of a whole number of vertical intervals and a line position.

Settings arrive as a single-cycle load strobe that carries a drive mode (monitoring or recording), a two-bit shutter mode, an 8-bit frame count, a 10-bit line value and an expose flag. A load is refused when the line value is outside the legal range for the requested drive mode. A load is also ignored while a long exposure is counting down. The field is identified by sampling the horizontal sync level a fixed number of clock cycles after each vertical sync fall.

Top module: `shut_seq_top`

## Requirements
- R1: After reset, every output is low, and no readout line is flagged before the first vertical sync fall, however many horizontal sync falls arrive.
- R2: The line counter returns to 0 on a vertical sync fall and advances by one on each horizontal sync fall, stopping at 524. The readout line is line 9, the line that begins at the 9th horizontal fall.
- R3: When shutter mode bit 0 is 0 (codes 00 and 10), readout occurs every frame and the discharge enable stays low. The write-enable window is high from line 10 until the next vertical sync fall in every frame that had a readout.
- R4: In mode 01 with recording drive (cfg_rec = 1), the discharge enable is high on lines 10 through 9 + line value, limited by the last line (524). It is high only in frames that had a readout.
- R5: In mode 01 with monitoring drive (cfg_rec = 0), the discharge enable is high on lines 10 through 9 + (line value − 106h). In even fields the window is one line longer. Line value 107h therefore gives one line in odd fields and two lines in even fields.
- R6: FIELD_DLY cycles after the vertical sync fall, hsync_lvl is sampled into field_even. A low level means an odd field (0) and a high level means an even field (1).
- R7: A load is rejected whole, and the previous settings are kept, when the line value is above 20Ch in recording drive, or outside 107h..20Ch in monitoring drive.
- R8: With the expose flag set, the discharge enable is high on line 10 of each readout frame, even when the shutter mode is stopped.
- R9: In mode 01 with frame count N > 0, each readout is followed by N frames with no readout, no write window and no discharge. busy is high from the line after the readout until the next readout frame begins.
- R10: A load strobe that arrives while busy is high leaves the settings unchanged.
- R11: A frame that begins while mode 11 is active has no readout. Readout resumes in the first frame that begins with mode 01 active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync_fall | input | 1 | Single-cycle strobe for a vertical sync fall |
| hsync_fall | input | 1 | Single-cycle strobe for a horizontal sync fall |
| hsync_lvl | input | 1 | Synchronised horizontal sync level, used for field detection |
| cfg_load | input | 1 | Load strobe for the cfg_* settings |
| cfg_rec | input | 1 | Drive mode: 1 = recording, 0 = monitoring |
| cfg_mode | input | 2 | Shutter mode: x0 = stopped, 01 = combined shutter, 11 = readout hold-off |
| cfg_frames | input | 8 | Extra vertical intervals in the exposure |
| cfg_line | input | 10 | Line value at which discharge stops |
| cfg_expose | input | 1 | One discharge line after each readout |
| xsub_en | output | 1 | Discharge enable for the current line |
| readout_line | output | 1 | Current line is the readout line |
| field_even | output | 1 | Field identity: 1 = even |
| wen_window | output | 1 | Write-enable window after readout |
| busy | output | 1 | Long exposure in progress; loads ignored |

## Verification
A wrong line count moves the readout flag and both ends of the discharge window within the first frame after a vertical sync. Every line is compared, so the error appears at the line where it first occurs. A hold counter with a bad count changes how many frames have readout and how many are skipped. That shows up one to three frames later as a readout that is missing or comes too early, and as busy at the wrong level. A settings register that accepts an illegal or blocked load changes the end of the discharge window in the next readout frame.

// File: rtl/shut_seq_pkg.sv
package shut_seq_pkg;
   localparam int FRM_W  = 8;
   localparam int LVAL_W = 10;

   localparam logic [1:0] SM_COMBINED = 2'b01;
   localparam logic [1:0] SM_HOLDOFF  = 2'b11;

   typedef struct packed {
      logic              rec;
      logic [1:0]        mode;
      logic [FRM_W-1:0]  frames;
      logic [LVAL_W-1:0] line;
      logic              expose;
   } shut_cfg_t;
endpackage

// File: rtl/shut_line_tracker.sv
module shut_line_tracker #(
   parameter int LINES     = 525,
   parameter int FIELD_DLY = 96,
   localparam int LINE_W   = $clog2(LINES),
   localparam int DLY_W    = (FIELD_DLY > 1) ? $clog2(FIELD_DLY + 1) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vs,
   input  logic              hs,
   input  logic              hs_lvl,
   output logic [LINE_W-1:0] line_cnt,
   output logic              field_even
);
   localparam logic [LINE_W-1:0] LAST = LINE_W'(LINES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         line_cnt <= LAST;
      else if (vs)
         line_cnt <= '0;
      else if (hs && line_cnt != LAST)
         line_cnt <= line_cnt + 1'b1;
   end

   generate
      if (FIELD_DLY == 0) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  field_even <= 1'b0;
            else if (vs) field_even <= hs_lvl;
         end
      end else begin : g_delayed
         logic [DLY_W-1:0] dly;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dly        <= '0;
               field_even <= 1'b0;
            end else if (vs) begin
               dly <= DLY_W'(FIELD_DLY);
            end else if (dly != '0) begin
               dly <= dly - 1'b1;
               if (dly == DLY_W'(1)) field_even <= hs_lvl;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/shut_cfg_reg.sv
module shut_cfg_reg
   import shut_seq_pkg::*;
#(
   parameter int REC_MAX = 'h20C,
   parameter int MON_MIN = 'h107
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      load,
   input  logic      busy,
   input  shut_cfg_t nxt,
   output shut_cfg_t act
);
   logic line_ok;

   always_comb begin
      if (nxt.rec)
         line_ok = (nxt.line <= LVAL_W'(REC_MAX));
      else
         line_ok = (nxt.line >= LVAL_W'(MON_MIN)) && (nxt.line <= LVAL_W'(REC_MAX));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         act <= '0;
      else if (load && !busy && line_ok)
         act <= nxt;
   end
endmodule

// File: rtl/shut_frame_ctrl.sv
module shut_frame_ctrl
   import shut_seq_pkg::*;
#(
   parameter int LINE_W  = 10,
   parameter int READOUT = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vs,
   input  logic              hs,
   input  logic [LINE_W-1:0] line_cnt,
   input  logic [1:0]        mode,
   input  logic [FRM_W-1:0]  frames,
   output logic              readout_now,
   output logic              rd_seen,
   output logic              busy
);
   logic [FRM_W-1:0] hold;
   logic             skip_frame;
   logic             frame_sup;

   assign readout_now = (line_cnt == LINE_W'(READOUT)) && !skip_frame && !frame_sup;
   assign busy        = (hold != '0) || skip_frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold       <= '0;
         skip_frame <= 1'b0;
         frame_sup  <= 1'b0;
         rd_seen    <= 1'b0;
      end else if (vs) begin
         rd_seen   <= 1'b0;
         frame_sup <= (mode == SM_HOLDOFF);
         if (hold != '0) begin
            skip_frame <= 1'b1;
            hold       <= hold - 1'b1;
         end else begin
            skip_frame <= 1'b0;
         end
      end else if (hs && readout_now) begin
         rd_seen <= 1'b1;
         hold    <= (mode == SM_COMBINED) ? frames : '0;
      end
   end
endmodule

// File: rtl/shut_seq_top.sv
module shut_seq_top
   import shut_seq_pkg::*;
#(
   parameter int LINES     = 525,
   parameter int READOUT   = 9,
   parameter int FIELD_DLY = 96,
   parameter int REC_MAX   = 'h20C,
   parameter int MON_MIN   = 'h107
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync_fall,
   input  logic              hsync_fall,
   input  logic              hsync_lvl,
   input  logic              cfg_load,
   input  logic              cfg_rec,
   input  logic [1:0]        cfg_mode,
   input  logic [FRM_W-1:0]  cfg_frames,
   input  logic [LVAL_W-1:0] cfg_line,
   input  logic              cfg_expose,
   output logic              xsub_en,
   output logic              readout_line,
   output logic              field_even,
   output logic              wen_window,
   output logic              busy
);
   localparam int LINE_W  = $clog2(LINES);
   localparam int CW      = ((LINE_W > LVAL_W) ? LINE_W : LVAL_W) + 1;
   localparam int MON_OFS = MON_MIN - 1;

   generate
      if (READOUT < 1 || READOUT >= LINES - 1) begin : g_bad_readout
         $error("READOUT must lie inside the frame");
      end
      if (REC_MAX >= (1 << LVAL_W) || MON_MIN > REC_MAX || MON_MIN < 1) begin : g_bad_range
         $error("line value range does not fit the field width");
      end
   endgenerate

   shut_cfg_t         nxt, act;
   logic [LINE_W-1:0] line_cnt;
   logic              rd_seen;
   logic [CW-1:0]     past, win;

   assign nxt = '{rec: cfg_rec, mode: cfg_mode, frames: cfg_frames,
                  line: cfg_line, expose: cfg_expose};

   shut_line_tracker #(.LINES(LINES), .FIELD_DLY(FIELD_DLY)) i_track (
      .clk(clk), .rst_n(rst_n), .vs(vsync_fall), .hs(hsync_fall),
      .hs_lvl(hsync_lvl), .line_cnt(line_cnt), .field_even(field_even));

   shut_cfg_reg #(.REC_MAX(REC_MAX), .MON_MIN(MON_MIN)) i_cfg (
      .clk(clk), .rst_n(rst_n), .load(cfg_load), .busy(busy),
      .nxt(nxt), .act(act));

   shut_frame_ctrl #(.LINE_W(LINE_W), .READOUT(READOUT)) i_frame (
      .clk(clk), .rst_n(rst_n), .vs(vsync_fall), .hs(hsync_fall),
      .line_cnt(line_cnt), .mode(act.mode), .frames(act.frames),
      .readout_now(readout_line), .rd_seen(rd_seen), .busy(busy));

   // lines elapsed since readout and the discharge window end in the same units
   always_comb begin
      past = CW'(line_cnt) - CW'(READOUT);
      if (act.rec)
         win = CW'(act.line);
      else
         win = CW'(act.line) - CW'(MON_OFS) + CW'(field_even);
   end

   assign xsub_en    = rd_seen && (((act.mode == SM_COMBINED) && (past <= win)) ||
                                   (act.expose && (past == CW'(1))));
   assign wen_window = rd_seen;
endmodule

// File: rtl/shut_seq_chk.sv
module shut_seq_chk
   import shut_seq_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      vsync_fall,
   input logic      cfg_load,
   input logic      xsub_en,
   input logic      readout_line,
   input logic      wen_window,
   input logic      busy,
   input shut_cfg_t act
);
   AST_RD_XSUB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      readout_line |-> !xsub_en);                                        // R4
   AST_XSUB_IN_WEN: assert property (@(posedge clk) disable iff (!rst_n)
      xsub_en |-> wen_window);                                           // R3
   AST_VSYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      vsync_fall |=> (!wen_window && !readout_line));                    // R2
   AST_BUSY_NO_READOUT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !readout_line);                                           // R9
   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy || !cfg_load) |=> $stable(act));                             // R10
   AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!act.mode[0] && !act.expose) |-> !xsub_en);                       // R3
endmodule

bind shut_seq_top shut_seq_chk i_chk (
   .clk(clk), .rst_n(rst_n), .vsync_fall(vsync_fall), .cfg_load(cfg_load),
   .xsub_en(xsub_en), .readout_line(readout_line), .wen_window(wen_window),
   .busy(busy), .act(act));

// File: tb/test_shut_seq_top.sv
module test_shut_seq_top;
   localparam int FIELD_DLY = 96;
   localparam int LAST_LN   = 524;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vsync_fall = 1'b0, hsync_fall = 1'b0, hsync_lvl = 1'b0;
   logic cfg_load = 1'b0, cfg_rec = 1'b0, cfg_expose = 1'b0;
   logic [1:0] cfg_mode = 2'b00;
   logic [7:0] cfg_frames = 8'd0;
   logic [9:0] cfg_line = 10'd0;
   logic xsub_en, readout_line, field_even, wen_window, busy;

   int n_chk = 0;
   int n_bad = 0;

   // settings applied by run_frame at a chosen line
   logic       mid_rec;
   logic [1:0] mid_mode;
   logic [7:0] mid_frames;
   logic [9:0] mid_line;

   always #4 clk = ~clk;

   shut_seq_top i_shut_seq_top (
      .clk(clk), .rst_n(rst_n), .vsync_fall(vsync_fall), .hsync_fall(hsync_fall),
      .hsync_lvl(hsync_lvl), .cfg_load(cfg_load), .cfg_rec(cfg_rec),
      .cfg_mode(cfg_mode), .cfg_frames(cfg_frames), .cfg_line(cfg_line),
      .cfg_expose(cfg_expose), .xsub_en(xsub_en), .readout_line(readout_line),
      .field_even(field_even), .wen_window(wen_window), .busy(busy));

   task automatic check(input string req, input logic act_v, input logic exp_v, input int ln);
      n_chk++;
      if (act_v !== exp_v) begin
         n_bad++;
         if (n_bad <= 30)
            $display("FAIL %s line %0d: got %b expected %b", req, ln, act_v, exp_v);
      end
   endtask

   task automatic load_cfg(input logic rec, input logic [1:0] md, input logic [7:0] fr,
                           input logic [9:0] ln, input logic ex);
      @(negedge clk);
      cfg_rec = rec; cfg_mode = md; cfg_frames = fr; cfg_line = ln; cfg_expose = ex;
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   task automatic pulse_hs();
      @(negedge clk); hsync_fall = 1'b1;
      @(negedge clk); hsync_fall = 1'b0;
   endtask

   // one whole frame; every line is compared with the expected readout, window and discharge
   task automatic run_frame(input logic lvl, input logic exp_rd, input int xlast, input int load_at);
      @(negedge clk); hsync_lvl = lvl; vsync_fall = 1'b1;
      @(negedge clk); vsync_fall = 1'b0;
      repeat (FIELD_DLY + 2) @(negedge clk);
      check("R6 field", field_even, lvl, 0);
      for (int ln = 0; ln <= LAST_LN; ln++) begin
         if (ln > 0) pulse_hs();
         check("R2 readout", readout_line, exp_rd && ln == 9, ln);
         check("R3 wen", wen_window, exp_rd && ln >= 10, ln);
         check("R4/R5/R8 xsub", xsub_en, exp_rd && ln >= 10 && ln <= xlast, ln);
         if (ln == load_at) load_cfg(mid_rec, mid_mode, mid_frames, mid_line, 1'b0);
      end
   endtask

   task automatic t_reset();
      check("R1 xsub", xsub_en, 1'b0, -1);
      check("R1 readout", readout_line, 1'b0, -1);
      check("R1 wen", wen_window, 1'b0, -1);
      check("R1 busy", busy, 1'b0, -1);
      check("R1 field", field_even, 1'b0, -1);
      for (int i = 0; i < 12; i++) begin
         pulse_hs();
         check("R1 no readout before vsync", readout_line, 1'b0, i);
      end
   endtask

   task automatic t_stopped();
      load_cfg(1'b1, 2'b00, 8'd0, 10'h000, 1'b0);
      run_frame(1'b0, 1'b1, 0, -1);                            // R3
      load_cfg(1'b1, 2'b10, 8'd0, 10'h20C, 1'b0);
      run_frame(1'b1, 1'b1, 0, -1);                            // R3 code 10
   endtask

   task automatic t_recording();
      load_cfg(1'b1, 2'b01, 8'd0, 10'h20C, 1'b0);
      run_frame(1'b0, 1'b1, LAST_LN, -1);                      // R4 whole interval
      load_cfg(1'b1, 2'b01, 8'd0, 10'h100, 1'b0);
      run_frame(1'b1, 1'b1, 9 + 'h100, -1);                    // R4
   endtask

   task automatic t_monitoring();
      load_cfg(1'b0, 2'b01, 8'd0, 10'h107, 1'b0);
      run_frame(1'b0, 1'b1, 10, -1);                           // R5 odd: one line
      run_frame(1'b1, 1'b1, 11, -1);                           // R5 even: two lines
      load_cfg(1'b0, 2'b01, 8'd0, 10'h20C, 1'b0);
      run_frame(1'b0, 1'b1, 9 + 262, -1);                      // R5
   endtask

   task automatic t_reject();
      load_cfg(1'b0, 2'b01, 8'd0, 10'h050, 1'b0);              // R7 below monitoring range
      run_frame(1'b0, 1'b1, 9 + 262, -1);
      load_cfg(1'b1, 2'b01, 8'd0, 10'h20D, 1'b0);              // R7 above recording range
      run_frame(1'b1, 1'b1, 9 + 263, -1);
   endtask

   task automatic t_expose();
      load_cfg(1'b1, 2'b00, 8'd0, 10'h000, 1'b1);
      run_frame(1'b0, 1'b1, 10, -1);                           // R8
   endtask

   task automatic t_long();
      load_cfg(1'b1, 2'b01, 8'd2, 10'h100, 1'b0);
      mid_rec = 1'b1; mid_mode = 2'b01; mid_frames = 8'd0; mid_line = 10'h20C;
      run_frame(1'b0, 1'b1, 9 + 'h100, 300);                   // R10 load while busy
      check("R9 busy after readout", busy, 1'b1, LAST_LN);
      run_frame(1'b0, 1'b0, 0, -1);                            // R9 skipped
      check("R9 busy in skipped frame", busy, 1'b1, LAST_LN);
      run_frame(1'b0, 1'b0, 0, -1);                            // R9 skipped
      run_frame(1'b0, 1'b1, 9 + 'h100, -1);                    // R10 old window kept
      run_frame(1'b0, 1'b0, 0, -1);
      run_frame(1'b0, 1'b0, 0, -1);
      mid_mode = 2'b00; mid_line = 10'h000;
      run_frame(1'b0, 1'b1, 0, 2);                             // R9 free again, load taken
      check("R9 busy released", busy, 1'b0, LAST_LN);
   endtask

   task automatic t_holdoff();
      load_cfg(1'b1, 2'b11, 8'd0, 10'h100, 1'b0);
      run_frame(1'b0, 1'b0, 0, -1);                            // R11 suppressed
      mid_rec = 1'b1; mid_mode = 2'b01; mid_frames = 8'd0; mid_line = 10'h100;
      run_frame(1'b0, 1'b0, 0, 3);                             // R11 still suppressed
      run_frame(1'b0, 1'b1, 9 + 'h100, -1);                    // R11 resumed
   endtask

   initial begin
      mid_rec = 1'b0; mid_mode = 2'b00; mid_frames = 8'd0; mid_line = 10'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_stopped();
      t_recording();
      t_monitoring();
      t_reject();
      t_expose();
      t_long();
      t_holdoff();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule